// File: doc/BRIEF.md
# Scan Broadcaster and XOR Compactor

This block sits between a few primary scan pins and a larger population of short internal scan chains. The design has NUM_GROUPS groups, and each group holds SPLIT short chains that together replace one long chain. In compressed mode every short chain is loaded at the same time. The first chain of a group takes its scan pin directly. Each other chain takes that pin XORed with a second pin chosen by its position, so the chains of a group are not all fed the same stream. On the unload side, the last cells of the chains in a group are XORed together into that group's single scan output.

In serial mode the chains of a group are stitched end to end: each chain feeds the next and the last chain drives the scan output. The group then behaves as its original long chain, which is how failing patterns are diagnosed. A registered mode bit selects between the two modes. It takes a new value only while shifting is stopped, so a load never switches modes halfway. The data path is purely combinational, and the chains themselves live outside the block.

Top module: `scan_bcast_compactor`

## Requirements
- R1: After reset is released the block is in compressed mode, before any mode request has been taken.
- R2: In compressed mode, chainIn bit g*SPLIT (chain 0 of group g) equals scanIn[g].
- R3: In compressed mode, chainIn bit g*SPLIT+j for 0 < j < SPLIT equals scanIn[g] XOR scanIn[(g+j) mod NUM_GROUPS]; SPLIT must not exceed NUM_GROUPS.
- R4: In compressed mode, scanOut[g] equals the XOR of chainOut bits g*SPLIT through g*SPLIT+SPLIT-1, in the same cycle.
- R5: In serial mode, chainIn bit g*SPLIT equals scanIn[g], and chainIn bit g*SPLIT+j for j > 0 equals chainOut bit g*SPLIT+j-1.
- R6: In serial mode, scanOut[g] equals chainOut bit g*SPLIT+SPLIT-1.
- R7: serialMode (1 = serial, 0 = compressed) is taken at a rising clock edge only when scanEn is low, and it governs from the next cycle on. While scanEn is high, changes on serialMode have no effect.
- R8: scanOut[g] and the chain inputs of group g depend only on scanIn and on the chainOut bits of group g. Corrupt values in one group's chains leave every other group's scan output and chain inputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock |
| rstN | input | 1 | Asynchronous active-low reset of the mode register |
| scanEn | input | 1 | High while chains shift; mode requests are taken only while it is low |
| serialMode | input | 1 | Mode request: 1 selects stitched long chains, 0 selects compressed |
| scanIn | input | NUM_GROUPS | Primary scan input pins, one per group |
| scanOut | output | NUM_GROUPS | Primary scan output pins, one per group |
| chainIn | output | NUM_GROUPS*SPLIT | Serial input of each short chain, group-major order |
| chainOut | input | NUM_GROUPS*SPLIT | Last cell of each short chain, group-major order |

## Verification
The hardest case to reach from the ports is group isolation. An unknown value has to sit inside one group's chains while every other group keeps known contents. A two-state simulation has no X to inject, so the bench models the chains itself and flips random bits in every chain of one group only. That bit pattern is kept away from the reference model, which acts as the corruption. The bench then unloads in both compressed and stitched modes. The corrupted group is left unchecked, and every other group's scan output and every chain input that does not hang off a corrupted chain are still compared on each cycle. Mode requests made while shifting are also driven on purpose, so the bench can confirm the mode does not move.

// File: rtl/scan_bcast_pkg.sv
package scan_bcast_pkg;

  // Strobes from the mode control to the datapath; exactly one is high.
  typedef struct packed {
    logic stitch;     // chains of a group concatenated into one long chain
    logic broadcast;  // chains loaded in parallel, outputs XOR-compacted
  } scanStrobe_t;

endpackage

// File: rtl/scan_mode_ctrl.sv
module scan_mode_ctrl
  import scan_bcast_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        scanEn,
  input  logic        serialMode,
  output scanStrobe_t strobe
);

  logic modeQ;

  // The mode register loads only while shifting is stopped.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ <= 1'b0;
    end else if (!scanEn) begin
      modeQ <= serialMode;
    end
  end

  always_comb begin
    strobe.stitch    = modeQ;
    strobe.broadcast = ~modeQ;
  end

endmodule

// File: rtl/scan_bcast_datapath.sv
module scan_bcast_datapath
  import scan_bcast_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int SPLIT      = 4
) (
  input  scanStrobe_t                       strobe,
  input  logic [NUM_GROUPS-1:0]             scanIn,
  input  logic [NUM_GROUPS*SPLIT-1:0]       chainOut,
  output logic [NUM_GROUPS*SPLIT-1:0]       chainIn,
  output logic [NUM_GROUPS-1:0]             scanOut
);

  localparam int NUM_CHAINS = NUM_GROUPS * SPLIT;

  logic [NUM_CHAINS-1:0] bcastVal;
  logic [NUM_CHAINS-1:0] stitchVal;
  logic [NUM_GROUPS-1:0] compactVal;
  logic [NUM_GROUPS-1:0] tailVal;

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gGroup
    // Broadcaster and stitch sources for each chain of the group.
    for (genvar j = 0; j < SPLIT; j++) begin : gChain
      localparam int K       = g * SPLIT + j;
      localparam int PARTNER = (g + j) % NUM_GROUPS;
      if (j == 0) begin : gHead
        assign bcastVal[K]  = scanIn[g];
        assign stitchVal[K] = scanIn[g];
      end else begin : gBody
        assign bcastVal[K]  = scanIn[g] ^ scanIn[PARTNER];
        assign stitchVal[K] = chainOut[K-1];
      end
    end
    // Compactor tree over this group only.
    assign compactVal[g] = ^chainOut[g*SPLIT +: SPLIT];
    assign tailVal[g]    = chainOut[g*SPLIT + SPLIT - 1];
  end

  // AND-OR select driven by the one-hot strobes.
  assign chainIn = (bcastVal  & {NUM_CHAINS{strobe.broadcast}})
                 | (stitchVal & {NUM_CHAINS{strobe.stitch}});
  assign scanOut = (compactVal & {NUM_GROUPS{strobe.broadcast}})
                 | (tailVal    & {NUM_GROUPS{strobe.stitch}});

endmodule

// File: rtl/scan_bcast_compactor.sv
module scan_bcast_compactor
  import scan_bcast_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int SPLIT      = 4
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        scanEn,
  input  logic                        serialMode,
  input  logic [NUM_GROUPS-1:0]       scanIn,
  output logic [NUM_GROUPS-1:0]       scanOut,
  output logic [NUM_GROUPS*SPLIT-1:0] chainIn,
  input  logic [NUM_GROUPS*SPLIT-1:0] chainOut
);

  scanStrobe_t strobe;

  scan_mode_ctrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .scanEn     (scanEn),
    .serialMode (serialMode),
    .strobe     (strobe)
  );

  scan_bcast_datapath #(
    .NUM_GROUPS (NUM_GROUPS),
    .SPLIT      (SPLIT)
  ) uPath (
    .strobe   (strobe),
    .scanIn   (scanIn),
    .chainOut (chainOut),
    .chainIn  (chainIn),
    .scanOut  (scanOut)
  );

endmodule

// File: rtl/scan_bcast_checker.sv
module scan_bcast_checker #(
  parameter int NUM_GROUPS = 4,
  parameter int SPLIT      = 4
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        scanEn,
  input logic                        serialMode,
  input logic                        stitchNow,
  input logic [NUM_GROUPS-1:0]       scanIn,
  input logic [NUM_GROUPS-1:0]       scanOut,
  input logic [NUM_GROUPS*SPLIT-1:0] chainIn,
  input logic [NUM_GROUPS*SPLIT-1:0] chainOut
);

  AST_RESET_COMPRESSED: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> !stitchNow); // R1

  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
    scanEn |=> $stable(stitchNow)); // R7

  AST_MODE_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    !scanEn |=> stitchNow == $past(serialMode)); // R7

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : gGrp
    // Each group's output uses only its own chains (R8 via R4/R6).
    AST_COMPACT_XOR: assert property (@(posedge clk) disable iff (!rstN)
      !stitchNow |-> scanOut[g] == ^chainOut[g*SPLIT +: SPLIT]); // R4

    AST_STITCH_TAIL: assert property (@(posedge clk) disable iff (!rstN)
      stitchNow |-> scanOut[g] == chainOut[g*SPLIT + SPLIT - 1]); // R6

    AST_HEAD_DIRECT: assert property (@(posedge clk) disable iff (!rstN)
      chainIn[g*SPLIT] == scanIn[g]); // R2

    for (genvar j = 1; j < SPLIT; j++) begin : gCh
      AST_BCAST_MIX: assert property (@(posedge clk) disable iff (!rstN)
        !stitchNow |-> chainIn[g*SPLIT+j] ==
          (scanIn[g] ^ scanIn[(g+j) % NUM_GROUPS])); // R3

      AST_STITCH_LINK: assert property (@(posedge clk) disable iff (!rstN)
        stitchNow |-> chainIn[g*SPLIT+j] == chainOut[g*SPLIT+j-1]); // R5
    end
  end

endmodule

bind scan_bcast_compactor scan_bcast_checker #(
  .NUM_GROUPS (NUM_GROUPS),
  .SPLIT      (SPLIT)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .scanEn     (scanEn),
  .serialMode (serialMode),
  .stitchNow  (strobe.stitch),
  .scanIn     (scanIn),
  .scanOut    (scanOut),
  .chainIn    (chainIn),
  .chainOut   (chainOut)
);

// File: tb/tb_scan_bcast_compactor.sv
module tb_scan_bcast_compactor;

  localparam int G   = 4;
  localparam int S   = 4;
  localparam int NC  = G * S;
  localparam int LEN = 8;

  logic clk = 1'b0;
  always #4 clk = ~clk;  // 125 MHz

  logic          rstN = 1'b0;
  logic          scanEn = 1'b0;
  logic          serialMode = 1'b0;
  logic [G-1:0]  scanIn = '0;
  logic [G-1:0]  scanOut;
  logic [NC-1:0] chainIn;
  logic [NC-1:0] chainOut;

  scan_bcast_compactor #(.NUM_GROUPS(G), .SPLIT(S)) dut (
    .clk(clk), .rstN(rstN), .scanEn(scanEn), .serialMode(serialMode),
    .scanIn(scanIn), .scanOut(scanOut), .chainIn(chainIn), .chainOut(chainOut)
  );

  // Environment: the short chains, bit LEN-1 is the last cell.
  logic [LEN-1:0] benchChain [NC];
  always_comb begin
    for (int k = 0; k < NC; k++) chainOut[k] = benchChain[k][LEN-1];
  end

  // Reference model: one queue per chain, index 0 newest, LEN-1 oldest.
  bit    mdlQ [NC][$];
  logic  modeEff;
  int    maskGroup = -1;
  string phase = "R1";
  int    errors = 0;
  int    checks = 0;
  logic [NC-1:0] cinCap;

  function automatic logic expChainIn(int k);
    int g = k / S;
    int j = k % S;
    if (j == 0) return scanIn[g];
    if (modeEff) return mdlQ[k-1][LEN-1];
    return scanIn[g] ^ scanIn[(g + j) % G];
  endfunction

  function automatic logic expScanOut(int g);
    logic x = 1'b0;
    if (modeEff) return mdlQ[g*S + S - 1][LEN-1];
    for (int j = 0; j < S; j++) x ^= mdlQ[g*S + j][LEN-1];
    return x;
  endfunction

  task automatic checkOutputs();
    for (int k = 0; k < NC; k++) begin
      int g = k / S;
      int j = k % S;
      logic e;
      string req;
      // Stitched inputs of a corrupted group are unknown to the model.
      if (g == maskGroup && modeEff && j > 0) continue;
      e = expChainIn(k);
      req = modeEff ? "R5" : ((j == 0) ? "R2" : "R3");
      checks++;
      if (chainIn[k] !== e) begin
        errors++;
        $display("FAIL %s [%s] chainIn[%0d] actual=%b expected=%b", req, phase, k, chainIn[k], e);
      end
    end
    for (int g = 0; g < G; g++) begin
      logic e;
      if (g == maskGroup) continue;
      e = expScanOut(g);
      checks++;
      if (scanOut[g] !== e) begin
        errors++;
        $display("FAIL %s [%s] scanOut[%0d] actual=%b expected=%b",
                 modeEff ? "R6" : "R4", phase, g, scanOut[g], e);
      end
    end
  endtask

  task automatic checkContents();
    for (int k = 0; k < NC; k++) begin
      logic [LEN-1:0] e;
      if ((k / S) == maskGroup) continue;
      for (int i = 0; i < LEN; i++) e[i] = mdlQ[k][i];
      checks++;
      if (benchChain[k] !== e) begin
        errors++;
        $display("FAIL R8 [%s] chain %0d contents actual=%h expected=%h", phase, k, benchChain[k], e);
      end
    end
  endtask

  task automatic step(input logic [G-1:0] si, input logic se, input logic sm);
    logic [NC-1:0] expIns;
    @(negedge clk);
    scanIn = si; scanEn = se; serialMode = sm;
    #1;
    checkOutputs();
    cinCap = chainIn;
    for (int k = 0; k < NC; k++) expIns[k] = expChainIn(k);
    @(posedge clk);
    if (se) begin
      for (int k = 0; k < NC; k++) begin
        benchChain[k] = {benchChain[k][LEN-2:0], cinCap[k]};
        mdlQ[k].push_front(expIns[k]);
        void'(mdlQ[k].pop_back());
      end
    end else begin
      modeEff = sm;
    end
  endtask

  task automatic shiftRandom(int n, logic sm);
    for (int i = 0; i < n; i++) step(G'($urandom), 1'b1, sm);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    for (int k = 0; k < NC; k++) begin
      benchChain[k] = '0;
      for (int i = 0; i < LEN; i++) mdlQ[k].push_back(1'b0);
    end
    modeEff = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk) rstN = 1'b1;

    // R1: first cycles after reset behave as compressed, even with a serial
    // request raised while shifting.
    phase = "R1";
    shiftRandom(4, 1'b1);

    phase = "compressed";
    shiftRandom(40, 1'b0);
    checkContents();

    // R7: serial request while scanEn stays high must be ignored.
    phase = "R7";
    shiftRandom(12, 1'b1);
    checkContents();

    // Take serial mode while stopped, then shift stitched chains.
    step('0, 1'b0, 1'b1);
    phase = "serial";
    shiftRandom(3 * LEN * S, 1'b1);
    checkContents();

    // R7: compressed request while shifting keeps serial.
    phase = "R7";
    shiftRandom(10, 1'b0);

    // Back to compressed.
    step('0, 1'b0, 1'b0);
    phase = "compressed";
    shiftRandom(30, 1'b0);
    checkContents();

    // R8: corrupt every chain of group 2 behind the model's back.
    @(negedge clk);
    maskGroup = 2;
    for (int j = 0; j < S; j++)
      benchChain[2*S + j] ^= LEN'($urandom | 1);
    phase = "R8";
    shiftRandom(LEN + 4, 1'b0);
    checkContents();
    step('0, 1'b0, 1'b1);
    shiftRandom(LEN + 4, 1'b1);
    checkContents();

    // Restore known contents and finish with a clean compressed unload.
    @(negedge clk);
    for (int k = 0; k < NC; k++)
      for (int i = 0; i < LEN; i++) benchChain[k][i] = mdlQ[k][i];
    maskGroup = -1;
    step('0, 1'b0, 1'b0);
    phase = "compressed";
    shiftRandom(20, 1'b0);
    checkContents();

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule